// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock Register Block

This block is a real-time clock that a host sees as a file of byte-wide registers. The host reaches it through a single-byte read/write strobe port with an 8-bit address. Inside, a free-running 32-bit seconds counter advances once for every `TICKS_PER_SEC` pulses on `tick_in`. A 32-bit alarm compare value is checked against the counter on every second boundary. Both values are exposed as four byte registers each, with the most significant byte at the lowest address.

Software moves the counter one byte at a time. A read of the top time byte latches the whole counter into a shadow, and the three lower byte addresses return that shadow. This keeps a byte-by-byte read coherent even when a second boundary falls in the middle of it. Writes go the other way: the upper three bytes are staged, and the write of the least significant byte commits all four at once and restarts the sub-second prescaler.

An alarm hit sets a flag in a write-one-to-clear interrupt source bank. While any flag in any bank is set, `irq` stays high. An alarm hit can also pulse a wake request and/or a power-up request, according to two enable bits in control register 2. The block also holds the identification values, a force-control register that drives the block's force outputs, and two further write-one-to-clear banks that are fed by external event inputs.

Top module: `rtc_regblock`

## Requirements
- R1: After reset, the seconds counter is 0, the alarm holds 0xFFFFFFFF, all interrupt flags and both control registers read 0x00, and `irq`, `wake_req`, `pwrup_req`, `force_act` and `force_shdn` are all low.
- R2: A read of 0x00 returns `VENDOR_ID` and a read of 0x01 returns `MODEL_REV` (at least 0x40). Writes to these two addresses change nothing.
- R3: The counter increases by exactly one on every `TICKS_PER_SEC`-th `tick_in` pulse and carries across byte boundaries.
- R4: Writes to 0x70, 0x71 and 0x72 only stage bytes 31:24, 23:16 and 15:8. A write to 0x73 loads {staged bytes, written byte} into the counter and restarts the prescaler, so the next increment needs a full `TICKS_PER_SEC` pulses.
- R5: A read of 0x70 returns counter bits 31:24 and latches all 32 bits into a shadow. Reads of 0x71, 0x72 and 0x73 return shadow bits 23:16, 15:8 and 7:0.
- R6: Addresses 0x74 to 0x77 hold alarm bits 31:24 down to 7:0 and read back directly. When a second boundary brings the counter equal to the alarm, bit 3 of source register 0x10 is set.
- R7: An alarm value of 0xFFFFFFFF never produces a hit, even when the counter reaches 0xFFFFFFFF.
- R8: On an alarm hit, `wake_req` pulses for one cycle if bit 3 of 0x29 is set, and `pwrup_req` pulses for one cycle if bit 2 of 0x29 is set. The flag at 0x10 bit 3 is set regardless of these bits.
- R9: Source registers 0x10, 0x11 and 0x12 set their bits from `evt_src1`, `evt_src2` and `evt_vnd` pulses. Writing a 1 to a bit clears it, writing a 0 leaves it unchanged, and a set in the same cycle as a clear wins.
- R10: `irq` is high exactly while at least one bit of 0x10, 0x11 or 0x12 is set.
- R11: 0x28 stores bits 3:0 and reads its upper nibble as 0. `force_shdn` is bits 1:0 and `force_act` is bit 2. 0x29 stores and returns all 8 bits, including the reset-delay field in bits 7:4.
- R12: Reads of unmapped addresses return 0x00, and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Sub-second tick pulse, one cycle wide |
| wr_en | input | 1 | Single-byte write strobe |
| rd_en | input | 1 | Single-byte read strobe; `rdata` is valid on the next cycle |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| evt_src1 | input | 8 | Event pulses setting bank 0x10 |
| evt_src2 | input | 8 | Event pulses setting bank 0x11 |
| evt_vnd | input | 8 | Event pulses setting bank 0x12 |
| irq | output | 1 | Interrupt, high while any flag is set |
| wake_req | output | 1 | One-cycle wake-from-sleep request |
| pwrup_req | output | 1 | One-cycle power-up-from-shutdown request |
| force_act | output | 1 | Force-active control bit |
| force_shdn | output | 2 | Force-shutdown control field |

## Verification
The bench builds the block with `TICKS_PER_SEC` set to 4, with vendor ID 0x3C and model revision 0x42. With one second lasting four tick pulses, byte carries, a second boundary landing between the top-byte read and the lower-byte reads, the prescaler restart on commit, and the counter wrap past 0xFFFFFFFF are all reached within a few hundred cycles. The distinct ID values make a swapped or mis-decoded identification register show up at once.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Register byte addresses
  localparam logic [7:0] A_VID   = 8'h00;
  localparam logic [7:0] A_REV   = 8'h01;
  localparam logic [7:0] A_SRC1  = 8'h10;
  localparam logic [7:0] A_SRC2  = 8'h11;
  localparam logic [7:0] A_SRCV  = 8'h12;
  localparam logic [7:0] A_CTL1  = 8'h28;
  localparam logic [7:0] A_CTL2  = 8'h29;
  localparam logic [7:0] A_TIME  = 8'h70;  // MSB of counter, 0x73 = LSB
  localparam logic [7:0] A_ALARM = 8'h74;  // MSB of alarm, 0x77 = LSB

  localparam int ALARM_FLAG_BIT = 3;
  localparam logic [31:0] ALARM_OFF = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [3:0] rst_dly;
    logic       wake_en;
    logic       pwrup_en;
    logic [1:0] bus_chk;
  } ctl2_t;

  // Byte i of a word, i = 0 selects bits 31:24
  function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] i);
    return w[8*(3-int'(i)) +: 8];
  endfunction

  function automatic logic [31:0] put_byte(input logic [31:0] w, input logic [1:0] i,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[8*(3-int'(i)) +: 8] = b;
    return r;
  endfunction

  function automatic logic [31:0] next_second(input logic [31:0] c);
    return c + 32'd1;
  endfunction

endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_in,
  input  logic        load,
  input  logic [31:0] load_val,
  output logic [31:0] count,
  output logic        sec_evt
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] presc;

  assign sec_evt = tick_in && (presc == LAST) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      count <= '0;
    end else if (load) begin
      presc <= '0;
      count <= load_val;
    end else if (tick_in) begin
      if (presc == LAST) begin
        presc <= '0;
        count <= next_second(count);
      end else begin
        presc <= presc + PW'(1);
      end
    end
  end

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> count == $past(count) + 32'd1);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_in && !load) |=> $stable(count));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [1:0]  idx,
  input  logic [7:0]  wdata,
  input  logic [31:0] count,
  input  logic        sec_evt,
  output logic [31:0] alarm,
  output logic        hit
);
  logic armed;
  assign armed = (alarm != ALARM_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm <= ALARM_OFF;
      hit   <= 1'b0;
    end else begin
      if (we) alarm <= put_byte(alarm, idx, wdata);
      hit <= sec_evt && armed && (next_second(count) == alarm);
    end
  end

  // hit is high in the cycle the counter has just reached the alarm
  assert_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> count == $past(alarm));

  assert_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(alarm) != ALARM_OFF);

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~(clr_we ? clr_mask : '0)) | set;
  end

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && set == '0) |=> (flags & $past(clr_mask)) == '0);

  assert_setwins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> (flags & $past(set)) == $past(set));

  assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && set == '0) |=> $stable(flags));

endmodule

// File: rtl/rtc_regblock.sv
module rtc_regblock
  import rtc_pkg::*;
#(
  parameter int         TICKS_PER_SEC = 32768,
  parameter logic [7:0] VENDOR_ID     = 8'h3C,
  parameter logic [7:0] MODEL_REV     = 8'h42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] evt_src1,
  input  logic [7:0] evt_src2,
  input  logic [7:0] evt_vnd,
  output logic       irq,
  output logic       wake_req,
  output logic       pwrup_req,
  output logic       force_act,
  output logic [1:0] force_shdn
);
  localparam int NBANK = 3;

  logic [31:0] count, alarm, shadow;
  logic [23:0] stage;
  logic        sec_evt, alarm_hit;
  logic        time_hit_w, alarm_hit_w, load;
  logic [31:0] load_val;
  logic [3:0]  ctl1;
  ctl2_t       ctl2;
  logic [7:0]  rd_mux;
  logic        any_set;

  logic [7:0] bank_set   [NBANK];
  logic [7:0] bank_flags [NBANK];
  logic       bank_clr   [NBANK];

  // ---------------- write decode ----------------
  assign time_hit_w  = wr_en && (addr[7:2] == A_TIME[7:2]);
  assign alarm_hit_w = wr_en && (addr[7:2] == A_ALARM[7:2]);
  assign load        = time_hit_w && (addr[1:0] == 2'd3);
  assign load_val    = {stage, wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (time_hit_w && !load) begin
      stage <= put_byte({stage, 8'h00}, addr[1:0], wdata)[31:8];
    end
  end

  // ---------------- counter and alarm ----------------
  rtc_sec_counter #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .load     (load),
    .load_val (load_val),
    .count    (count),
    .sec_evt  (sec_evt)
  );

  rtc_alarm_cmp u_alm (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (alarm_hit_w),
    .idx     (addr[1:0]),
    .wdata   (wdata),
    .count   (count),
    .sec_evt (sec_evt),
    .alarm   (alarm),
    .hit     (alarm_hit)
  );

  // ---------------- interrupt source banks ----------------
  assign bank_set[0] = evt_src1 | (8'(alarm_hit) << ALARM_FLAG_BIT);
  assign bank_set[1] = evt_src2;
  assign bank_set[2] = evt_vnd;

  generate
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
      assign bank_clr[g] = wr_en && (addr == A_SRC1 + 8'(g));
      rtc_irq_flags #(.W(8)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (bank_set[g]),
        .clr_we   (bank_clr[g]),
        .clr_mask (wdata),
        .flags    (bank_flags[g])
      );
    end
  endgenerate

  assign irq     = |{bank_flags[0], bank_flags[1], bank_flags[2]};
  assign any_set = |{bank_set[0], bank_set[1], bank_set[2]};

  // ---------------- control registers and requests ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1      <= '0;
      ctl2      <= '0;
      wake_req  <= 1'b0;
      pwrup_req <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTL1) ctl1 <= wdata[3:0];
      if (wr_en && addr == A_CTL2) ctl2 <= ctl2_t'(wdata);
      wake_req  <= alarm_hit && ctl2.wake_en;
      pwrup_req <= alarm_hit && ctl2.pwrup_en;
    end
  end

  assign force_shdn = ctl1[1:0];
  assign force_act  = ctl1[2];

  // ---------------- read path ----------------
  always_comb begin
    rd_mux = 8'h00;
    case (addr)
      A_VID:            rd_mux = VENDOR_ID;
      A_REV:            rd_mux = MODEL_REV;
      A_SRC1:           rd_mux = bank_flags[0];
      A_SRC2:           rd_mux = bank_flags[1];
      A_SRCV:           rd_mux = bank_flags[2];
      A_CTL1:           rd_mux = {4'h0, ctl1};
      A_CTL2:           rd_mux = ctl2;
      A_TIME:           rd_mux = byte_of(count, 2'd0);
      A_TIME + 8'd1,
      A_TIME + 8'd2,
      A_TIME + 8'd3:    rd_mux = byte_of(shadow, addr[1:0]);
      A_ALARM,
      A_ALARM + 8'd1,
      A_ALARM + 8'd2,
      A_ALARM + 8'd3:   rd_mux = byte_of(alarm, addr[1:0]);
      default:          rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= 8'h00;
      shadow <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
      if (addr == A_TIME) shadow <= count;
    end
  end

  assert_snap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_TIME) |=> shadow == $past(count));

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(ctl2.wake_en) && $past(alarm_hit));

  assert_pwrup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwrup_req |-> $past(ctl2.pwrup_en) && $past(alarm_hit));

  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_set));

endmodule

// File: tb/tb_rtc_regblock.sv
module tb_rtc_regblock;
  localparam int         TPS = 4;
  localparam logic [7:0] VID = 8'h3C;
  localparam logic [7:0] REV = 8'h42;

  logic clk = 1'b0, rst_n = 1'b0, tick_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, ev1 = '0, ev2 = '0, evv = '0;
  logic [7:0] rdata;
  logic irq, wake_req, pwrup_req, force_act;
  logic [1:0] force_shdn;

  rtc_regblock #(.TICKS_PER_SEC(TPS), .VENDOR_ID(VID), .MODEL_REV(REV)) dut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .evt_src1(ev1), .evt_src2(ev2),
    .evt_vnd(evv), .irq(irq), .wake_req(wake_req), .pwrup_req(pwrup_req),
    .force_act(force_act), .force_shdn(force_shdn)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, wake_hits = 0, pwr_hits = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    wake_hits += int'(wake_req);
    pwr_hits  += int'(pwrup_req);
  end

  // {write, addr, data, expected read, requirement number}
  localparam int NV = 20;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'h28, 8'hFF, 8'h00, 4'd11},  // R11 upper nibble dropped
    {1'b0, 8'h28, 8'h00, 8'h0F, 4'd11},
    {1'b1, 8'h29, 8'hA1, 8'h00, 4'd11},  // R11 full byte incl. delay field
    {1'b0, 8'h29, 8'h00, 8'hA1, 4'd11},
    {1'b1, 8'h74, 8'h12, 8'h00, 4'd6},   // R6 alarm byte readback
    {1'b0, 8'h74, 8'h00, 8'h12, 4'd6},
    {1'b1, 8'h77, 8'h34, 8'h00, 4'd6},
    {1'b0, 8'h77, 8'h00, 8'h34, 4'd6},
    {1'b0, 8'h75, 8'h00, 8'hFF, 4'd6},
    {1'b0, 8'h00, 8'h00, VID,   4'd2},   // R2 identification
    {1'b0, 8'h01, 8'h00, REV,   4'd2},
    {1'b1, 8'h01, 8'h00, 8'h00, 4'd2},
    {1'b0, 8'h01, 8'h00, REV,   4'd2},
    {1'b1, 8'h00, 8'hFF, 8'h00, 4'd2},
    {1'b0, 8'h00, 8'h00, VID,   4'd2},
    {1'b0, 8'h50, 8'h00, 8'h00, 4'd12},  // R12 unmapped
    {1'b1, 8'h50, 8'h77, 8'h00, 4'd12},
    {1'b0, 8'h50, 8'h00, 8'h00, 4'd12},
    {1'b1, 8'h29, 8'h00, 8'h00, 4'd11},
    {1'b0, 8'h29, 8'h00, 8'h00, 4'd11}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd32(input logic [7:0] base, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(base + 8'(i), b);
      v = {v[23:0], b};
    end
  endtask

  task automatic wr32(input logic [7:0] base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(base + 8'(i), v[8*(3-i) +: 8]);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      report();
    end
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] w;
    int w0, p0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd32(8'h70, w); chk("R1 counter", w, 32'h0);
    rd32(8'h74, w); chk("R1 alarm", w, 32'hFFFF_FFFF);
    rd(8'h10, b);   chk("R1 src1", 32'(b), 32'h0);
    rd(8'h28, b);   chk("R1 ctl1", 32'(b), 32'h0);
    chk("R1 outputs", {27'h0, irq, wake_req, pwrup_req, force_shdn},
        32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      if (v[28]) wr(v[27:20], v[19:12]);
      else begin
        rd(v[27:20], b);
        chk($sformatf("R%0d table[%0d] addr %h", v[3:0], i, v[27:20]), 32'(b), 32'(v[11:4]));
      end
    end
    wr32(8'h74, 32'hFFFF_FFFF);
    wr(8'h28, 8'h00);

    // R4 staging without commit
    wr(8'h70, 8'h12);
    rd32(8'h70, w); chk("R4 staged not visible", w, 32'h0);
    wr(8'h71, 8'hFF); wr(8'h72, 8'hFF); wr(8'h73, 8'hFF);
    rd32(8'h70, w); chk("R4 commit", w, 32'h12FF_FFFF);

    // R3 prescaler, R5 snapshot across a carry
    ticks(TPS - 1);
    rd32(8'h70, w); chk("R3 before boundary", w, 32'h12FF_FFFF);
    rd(8'h70, b); chk("R5 top byte", 32'(b), 32'h12);
    ticks(1);
    rd(8'h71, b); chk("R5 shadow b2", 32'(b), 32'hFF);
    rd(8'h72, b); chk("R5 shadow b1", 32'(b), 32'hFF);
    rd(8'h73, b); chk("R5 shadow b0", 32'(b), 32'hFF);
    rd32(8'h70, w); chk("R3 carry", w, 32'h1300_0000);

    // R4 prescaler restart on commit
    ticks(2);
    wr32(8'h70, 32'h0000_0100);
    ticks(TPS - 1);
    rd32(8'h70, w); chk("R4 prescaler restarted", w, 32'h0000_0100);
    ticks(1);
    rd32(8'h70, w); chk("R3 step", w, 32'h0000_0101);

    // R6 and R8 wake path
    wr32(8'h74, 32'h0000_0103);
    wr(8'h29, 8'h08);
    w0 = wake_hits; p0 = pwr_hits;
    ticks(TPS);
    rd(8'h10, b); chk("R6 no early flag", 32'(b), 32'h00);
    chk("R10 irq low", 32'(irq), 32'h0);
    ticks(TPS);
    rd(8'h10, b); chk("R6 alarm flag", 32'(b), 32'h08);
    chk("R10 irq high", 32'(irq), 32'h1);
    chk("R8 wake one pulse", 32'(wake_hits - w0), 32'h1);
    chk("R8 no pwrup", 32'(pwr_hits - p0), 32'h0);
    wr(8'h10, 8'h08);
    rd(8'h10, b); chk("R9 w1c alarm flag", 32'(b), 32'h00);
    chk("R10 irq after clear", 32'(irq), 32'h0);

    // R8 power-up path
    wr(8'h29, 8'h04);
    wr(8'h77, 8'h05);
    w0 = wake_hits; p0 = pwr_hits;
    ticks(2 * TPS);
    chk("R8 pwrup one pulse", 32'(pwr_hits - p0), 32'h1);
    chk("R8 no wake", 32'(wake_hits - w0), 32'h0);
    wr(8'h10, 8'h08);

    // R8 both disabled: flag still set
    wr(8'h29, 8'h00);
    wr(8'h77, 8'h07);
    w0 = wake_hits; p0 = pwr_hits;
    ticks(2 * TPS);
    rd(8'h10, b); chk("R8 flag without enables", 32'(b), 32'h08);
    chk("R8 no pulses", 32'(wake_hits - w0 + pwr_hits - p0), 32'h0);
    wr(8'h10, 8'h08);

    // R7 disabled alarm and counter wrap
    wr32(8'h74, 32'hFFFF_FFFF);
    wr(8'h29, 8'h0C);
    wr32(8'h70, 32'hFFFF_FFFD);
    w0 = wake_hits;
    ticks(2 * TPS);
    rd32(8'h70, w); chk("R3 reach max", w, 32'hFFFF_FFFF);
    rd(8'h10, b); chk("R7 no hit at all-ones", 32'(b), 32'h00);
    ticks(TPS);
    rd32(8'h70, w); chk("R3 wrap", w, 32'h0);
    rd(8'h10, b); chk("R7 no hit after wrap", 32'(b), 32'h00);
    chk("R7 no wake", 32'(wake_hits - w0), 32'h0);
    wr(8'h29, 8'h00);

    // R9 external sources
    @(negedge clk); ev2 = 8'h01;
    @(negedge clk); ev2 = 8'h00;
    rd(8'h11, b); chk("R9 src2 set", 32'(b), 32'h01);
    chk("R10 irq from src2", 32'(irq), 32'h1);
    @(negedge clk); wr_en = 1'b1; addr = 8'h11; wdata = 8'h01; ev2 = 8'h01;
    @(negedge clk); wr_en = 1'b0; ev2 = 8'h00;
    rd(8'h11, b); chk("R9 set wins over clear", 32'(b), 32'h01);
    wr(8'h11, 8'h01);
    rd(8'h11, b); chk("R9 src2 cleared", 32'(b), 32'h00);
    @(negedge clk); ev1 = 8'h21;
    @(negedge clk); ev1 = 8'h00;
    wr(8'h10, 8'h01);
    rd(8'h10, b); chk("R9 zero bits keep", 32'(b), 32'h20);
    wr(8'h10, 8'h20);
    @(negedge clk); evv = 8'h80;
    @(negedge clk); evv = 8'h00;
    rd(8'h12, b); chk("R9 vendor set", 32'(b), 32'h80);
    wr(8'h12, 8'h80);
    rd(8'h12, b); chk("R9 vendor cleared", 32'(b), 32'h00);
    chk("R10 irq idle", 32'(irq), 32'h0);

    // R11 force outputs
    wr(8'h28, 8'h06);
    chk("R11 force_shdn", 32'(force_shdn), 32'h2);
    chk("R11 force_act", 32'(force_act), 32'h1);
    rd(8'h28, b); chk("R11 ctl1 read", 32'(b), 32'h06);

    // R12 unmapped write leaves time and alarm intact
    wr32(8'h74, 32'h0000_0999);
    wr(8'h7F, 8'h55);
    rd32(8'h74, w); chk("R12 alarm untouched", w, 32'h0000_0999);

    done = 1'b1;
    report();
  end

endmodule